// File: doc/BRIEF.md
# Machine Timer with Mixed-Width Register Access

This block keeps one free-running 64-bit time counter and, for every hart, a 64-bit compare value. A hart's timer-interrupt output is high while the time counter is at or above that hart's compare value. A processor reaches the registers over a simple single-cycle register bus. It can use a 32-bit access to touch one half of a register, or a 64-bit access to touch the whole register at once.

Each hart owns an 8-byte compare slot in a compare region. The time counter has its own 8-byte location. A 32-bit write merges into the half it targets and leaves the other half unchanged. A 64-bit write replaces the whole register in one cycle, so no other logic ever sees a half-written value. An access the block does not accept has no effect and reads back zero. Such accesses are a 64-bit access at the upper-half offset, a hart index beyond the configured count, a misaligned offset, or an unmapped address. Each one raises a single-cycle error pulse.

Top module: `mtimer_mixed`

## Requirements
- R1: After reset the time counter is zero, every compare value is all ones, and irq_o and err_o are low.
- R2: When no write hits the time counter, the counter increments by one on each clock where tick_i is high and holds otherwise.
- R3: In every cycle, irq_o[h] is high exactly when the time counter is greater than or equal to hart h's compare value, compared as unsigned numbers.
- R4: Hart h's compare slot starts at CMP_BASE + 8*h. A 32-bit access (size8_i=0) at slot offset 0 covers bits 31:0 and at offset 4 covers bits 63:32. Write data is taken from wdata_i[31:0], and a 32-bit write leaves the other half unchanged.
- R5: A 64-bit access (size8_i=1) at slot offset 0 reads or writes all 64 compare bits, and the new value is fully in place after a single clock.
- R6: A 64-bit access at offset 4 of a compare slot or at TIME_BASE+4 is illegal. It changes nothing and reads zero.
- R7: A read at TIME_BASE returns the low 32 bits for a 32-bit access and all 64 bits for a 64-bit access. A 32-bit read at TIME_BASE+4 returns the high 32 bits. Reads are combinational on the current value.
- R8: Writes to the time counter follow the same width and half-merge rules. A write in the same cycle as tick_i overrides the increment.
- R9: A compare-region access whose hart index is at or above NUM_HARTS is ignored and reads zero.
- R10: Slot offsets other than 0 and 4, and addresses outside both the compare region and the time location, are ignored and read zero.
- R11: err_o is high for exactly the one cycle after an accepted request (req_i high) that is illegal, and low after any legal request or idle cycle. rdata_o is zero when req_i is low, and its bits 63:32 are zero for 32-bit accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time counter increment enable |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| size8_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 64 | Write data (32-bit writes use bits 31:0) |
| rdata_o | output | 64 | Combinational read data |
| err_o | output | 1 | One-cycle pulse after an illegal access |
| irq_o | output | NUM_HARTS | Per-hart timer interrupt |

## Verification
Two functions can act in the same cycle: a bus write to the time counter and the tick increment. The same holds for a compare write and the interrupt comparison that uses the new value on the next cycle. The bench drives tick_i randomly while it issues full and half writes to the time location, and it directs one full write with tick_i high. It expects the written value with no increment. After every clock it checks each irq_o bit against a model that applies the write-over-tick priority. Compare writes are given values close to the running time, so that irq_o edges happen in the same cycles as the writes.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int unsigned TW = 64;
  localparam int unsigned HW = TW / 2;

  // replace one 32-bit half of a register, keep the other
  function automatic logic [TW-1:0] merge_half(input logic [TW-1:0] old_v,
                                               input logic [TW-1:0] wr_v,
                                               input logic          upper);
    merge_half = upper ? {wr_v[HW-1:0], old_v[HW-1:0]}
                       : {old_v[TW-1:HW], wr_v[HW-1:0]};
  endfunction

  function automatic logic [TW-1:0] next_value(input logic [TW-1:0] old_v,
                                               input logic [TW-1:0] wr_v,
                                               input logic          full,
                                               input logic          upper);
    next_value = full ? wr_v : merge_half(old_v, wr_v, upper);
  endfunction
endpackage

// File: rtl/mtimer_decode.sv
module mtimer_decode #(
  parameter int unsigned       ADDR_W    = 12,
  parameter int unsigned       NUM_HARTS = 4,
  parameter int unsigned       CMP_SLOTS = 8,
  parameter int unsigned       HART_W    = 3,
  parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
  parameter logic [ADDR_W-1:0] TIME_BASE = 12'h100
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              size8_i,
  output logic              cmp_hit_o,
  output logic              time_hit_o,
  output logic              upper_o,
  output logic [HART_W-1:0] hart_o,
  output logic              illegal_o
);
  localparam logic [ADDR_W:0]   CMP_SPAN = (ADDR_W+1)'(8 * CMP_SLOTS);
  localparam logic [ADDR_W-1:0] TIME_HI  = TIME_BASE + ADDR_W'(4);
  localparam logic [HART_W:0]   HART_LIM = (HART_W+1)'(NUM_HARTS);

  logic [ADDR_W-1:0] cmp_off;
  logic              in_cmp, hart_ok, off_ok;

  always_comb begin
    cmp_off    = addr_i - CMP_BASE;  // below-base addresses wrap high
    in_cmp     = {1'b0, cmp_off} < CMP_SPAN;
    hart_o     = cmp_off[3 +: HART_W];
    hart_ok    = {1'b0, hart_o} < HART_LIM;
    off_ok     = (addr_i[2:0] == 3'd0) || (addr_i[2:0] == 3'd4 && !size8_i);
    cmp_hit_o  = in_cmp && hart_ok && off_ok;
    time_hit_o = (addr_i == TIME_BASE) || (addr_i == TIME_HI && !size8_i);
    upper_o    = addr_i[2];
    illegal_o  = !(cmp_hit_o || time_hit_o);
  end
endmodule

// File: rtl/mtimer_time_ctr.sv
module mtimer_time_ctr
  import mtimer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic          full_i,
  input  logic          upper_i,
  input  logic [TW-1:0] wdata_i,
  output logic [TW-1:0] time_o
);
  logic [TW-1:0] time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     time_q <= '0;
    else if (wr_i)   time_q <= next_value(time_q, wdata_i, full_i, upper_i);
    else if (tick_i) time_q <= time_q + TW'(1);
  end

  assign time_o = time_q;

  a_r2_tick_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && tick_i |=> time_q == $past(time_q) + TW'(1));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && !tick_i |=> $stable(time_q));
  a_r8_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && full_i |=> time_q == $past(wdata_i));
endmodule

// File: rtl/mtimer_cmp_slot.sv
module mtimer_cmp_slot
  import mtimer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          full_i,
  input  logic          upper_i,
  input  logic [TW-1:0] wdata_i,
  input  logic [TW-1:0] time_i,
  output logic [TW-1:0] cmp_o,
  output logic          irq_o
);
  logic [TW-1:0] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cmp_q <= '1;
    else if (sel_i) cmp_q <= next_value(cmp_q, wdata_i, full_i, upper_i);
  end

  assign cmp_o = cmp_q;
  assign irq_o = time_i >= cmp_q;

  a_r6_unselected_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(cmp_q));
  a_r4_low_keeps_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && !full_i && !upper_i |=> cmp_q[TW-1:HW] == $past(cmp_q[TW-1:HW]));
  a_r4_high_keeps_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && !full_i && upper_i |=> cmp_q[HW-1:0] == $past(cmp_q[HW-1:0]));
  a_r5_full_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && full_i |=> cmp_q == $past(wdata_i));
endmodule

// File: rtl/mtimer_mixed.sv
module mtimer_mixed
  import mtimer_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 12,
  parameter int unsigned       NUM_HARTS = 4,
  parameter int unsigned       CMP_SLOTS = 8,   // >= NUM_HARTS
  parameter logic [ADDR_W-1:0] CMP_BASE  = '0,  // 8-byte aligned
  parameter logic [ADDR_W-1:0] TIME_BASE = 12'h100
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic                 size8_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [63:0]          wdata_i,
  output logic [63:0]          rdata_o,
  output logic                 err_o,
  output logic [NUM_HARTS-1:0] irq_o
);
  localparam int unsigned HART_W = (CMP_SLOTS > 1) ? $clog2(CMP_SLOTS) : 1;

  logic              cmp_hit, time_hit, upper, illegal;
  logic [HART_W-1:0] hart;
  logic              wr;
  logic [TW-1:0]     time_q, sel_cmp, src;
  logic [TW-1:0]     cmp_arr [NUM_HARTS];
  logic              err_q;

  mtimer_decode #(
    .ADDR_W(ADDR_W), .NUM_HARTS(NUM_HARTS), .CMP_SLOTS(CMP_SLOTS),
    .HART_W(HART_W), .CMP_BASE(CMP_BASE), .TIME_BASE(TIME_BASE)
  ) u_dec (
    .addr_i(addr_i), .size8_i(size8_i), .cmp_hit_o(cmp_hit),
    .time_hit_o(time_hit), .upper_o(upper), .hart_o(hart), .illegal_o(illegal)
  );

  assign wr = req_i && we_i;

  mtimer_time_ctr u_time (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr && time_hit),
    .full_i(size8_i), .upper_i(upper), .wdata_i(wdata_i), .time_o(time_q)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_slot
    mtimer_cmp_slot u_slot (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .sel_i(wr && cmp_hit && (hart == HART_W'(h))),
      .full_i(size8_i), .upper_i(upper), .wdata_i(wdata_i),
      .time_i(time_q), .cmp_o(cmp_arr[h]), .irq_o(irq_o[h])
    );
  end

  always_comb begin
    sel_cmp = '0;
    for (int h = 0; h < NUM_HARTS; h++)
      if (hart == HART_W'(h)) sel_cmp = cmp_arr[h];
    src     = cmp_hit ? sel_cmp : time_q;
    rdata_o = '0;
    if (req_i && !illegal)
      rdata_o = size8_i ? src : {32'h0, upper ? src[63:32] : src[31:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= req_i && illegal;
  end
  assign err_o = err_q;

  a_r11_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && illegal |=> err_o);
  a_r11_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && illegal) |=> !err_o);
  a_r9_bad_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && illegal |-> rdata_o == '0);
  a_r11_half_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !size8_i |-> rdata_o[63:32] == 32'h0);
  a_r11_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> rdata_o == '0);
endmodule

// File: tb/mtimer_mixed_test.sv
`timescale 1ns/1ps
module mtimer_mixed_test;
  localparam int NH = 4;
  localparam real CLK_NS = 20.0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, req = 0, we = 0, s8 = 0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic err;
  logic [NH-1:0] irq;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [63:0] m_time;
  logic [63:0] m_cmp [NH];

  always #(CLK_NS/2) clk = ~clk;

  mtimer_mixed uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .size8_i(s8), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .err_o(err), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit legal(input bit sz8, input int a);
    if (a < 64) return ((a >> 3) < NH) && ((a % 8) == 0 || ((a % 8) == 4 && !sz8));
    return (a == 256) || (a == 260 && !sz8);
  endfunction

  function automatic logic [63:0] exp_read(input bit sz8, input int a);
    logic [63:0] v;
    if (!legal(sz8, a)) return 64'h0;
    v = (a < 64) ? m_cmp[a >> 3] : m_time;
    if (sz8) return v;
    return (a % 8 == 4) ? {32'h0, v[63:32]} : {32'h0, v[31:0]};
  endfunction

  function automatic logic [63:0] merged(input logic [63:0] o, input logic [63:0] w, input bit sz8, input int a);
    if (sz8) return w;
    return (a % 8 == 4) ? {w[31:0], o[31:0]} : {o[63:32], w[31:0]};
  endfunction

  function automatic logic [NH-1:0] exp_irq();
    logic [NH-1:0] r;
    for (int h = 0; h < NH; h++) r[h] = (m_time >= m_cmp[h]);
    return r;
  endfunction

  // called at a negedge; returns at the next negedge
  task automatic cyc(input bit r, input bit w, input bit sz8, input int a,
                     input logic [63:0] d, input bit t, input string tag);
    bit ill, tw;
    req = r; we = w; s8 = sz8; addr = 12'(a); wdata = d; tick = t;
    #2;
    if (r) chk(rdata === exp_read(sz8, a), tag, rdata, exp_read(sz8, a));
    else   chk(rdata === 64'h0, "R11", rdata, 64'h0);
    ill = r && !legal(sz8, a);
    tw  = r && w && legal(sz8, a) && a >= 64;
    @(posedge clk);
    if (r && w && legal(sz8, a)) begin
      if (a < 64) m_cmp[a >> 3] = merged(m_cmp[a >> 3], d, sz8, a);
      else        m_time = merged(m_time, d, sz8, a);
    end
    if (!tw && t) m_time = m_time + 64'd1;
    @(negedge clk);
    chk(err === ill, "R11", {63'h0, err}, {63'h0, ill});
    chk(irq === exp_irq(), "R3", {60'h0, irq}, {60'h0, exp_irq()});
    req = 0; we = 0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_time = '0;
    for (int h = 0; h < NH; h++) m_cmp[h] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(irq === '0, "R1", {60'h0, irq}, 64'h0);
    chk(err === 1'b0, "R1", {63'h0, err}, 64'h0);
    cyc(1, 0, 1, 256, 0, 0, "R1");
    cyc(1, 0, 1, 0, 0, 0, "R1");
    // R2 hold and tick
    cyc(0, 0, 0, 0, 0, 0, "R2");
    cyc(1, 0, 1, 256, 0, 1, "R2");
    cyc(1, 0, 1, 256, 0, 1, "R2");
    // R5 full compare write/read
    cyc(1, 1, 1, 8, 64'h1122334455667788, 0, "R5");
    cyc(1, 0, 1, 8, 0, 0, "R5");
    cyc(1, 0, 0, 8, 0, 0, "R4");
    cyc(1, 0, 0, 12, 0, 0, "R4");
    // R4 half writes keep the other half
    cyc(1, 1, 0, 8, 64'hFFFFFFFF_AABBCCDD, 0, "R4");
    cyc(1, 0, 1, 8, 0, 0, "R4");
    cyc(1, 1, 0, 12, 64'h0000000099887766, 0, "R4");
    cyc(1, 0, 1, 8, 0, 0, "R4");
    // R6 8-byte at upper offset
    cyc(1, 1, 1, 12, 64'h0, 0, "R6");
    cyc(1, 0, 1, 8, 0, 0, "R6");
    cyc(1, 0, 1, 260, 0, 0, "R6");
    cyc(1, 1, 1, 260, 64'h5, 0, "R6");
    cyc(1, 0, 1, 256, 0, 0, "R6");
    // R9 hart beyond count
    cyc(1, 1, 1, 32, 64'h0, 0, "R9");
    cyc(1, 0, 1, 32, 0, 0, "R9");
    // R10 bad offsets and unmapped
    cyc(1, 1, 0, 2, 64'h0, 0, "R10");
    cyc(1, 1, 1, 128, 64'h0, 0, "R10");
    cyc(1, 0, 1, 0, 0, 0, "R10");
    // R8 write beats tick, half writes to time
    cyc(1, 1, 1, 256, 64'd100, 1, "R8");
    cyc(1, 0, 1, 256, 0, 0, "R8");
    cyc(1, 1, 0, 260, 64'h7, 1, "R8");
    cyc(1, 0, 0, 260, 0, 0, "R7");
    cyc(1, 0, 0, 256, 0, 0, "R7");
    cyc(1, 1, 1, 256, 64'd100, 0, "R8");
    // R3 interrupt edge
    cyc(1, 1, 1, 0, 64'd105, 0, "R3");
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 1, "R3");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int sel, a;
      bit w, z;
      logic [63:0] d;
      sel = $urandom_range(0, 9);
      if (sel < 5)       a = 8 * $urandom_range(0, 7) + 4 * $urandom_range(0, 1);
      else if (sel < 7)  a = 256 + 4 * $urandom_range(0, 1);
      else if (sel < 8)  a = 8 * $urandom_range(0, 7) + $urandom_range(0, 7);
      else               a = $urandom_range(0, 511);
      w = $urandom_range(0, 2) == 0;
      z = $urandom_range(0, 1);
      d = m_time + 64'($urandom_range(0, 12)) - 64'd4;
      if ($urandom_range(0, 3) == 0) d = {$urandom(), $urandom()};
      cyc($urandom_range(0, 4) != 0, w, z, a, d, $urandom_range(0, 1), "R5");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule